// File: doc/BRIEF.md
# Tone Steering Guard-Time Controller

This block sits behind a dual-tone decoder and decides when a decoded key press becomes a registered digit. The decoder supplies a signal-present flag and a 4-bit key code every clock. The controller demands that the flag stay high for a programmable number of clock cycles before it captures the code in an output register. A fixed number of cycles after that capture it raises a delayed strobe, so the code is already stable when the strobe rises.

Once a digit is held, short gaps in the flag are treated as dropouts and are ignored. Only an absence that lasts a second programmable number of cycles ends the digit, drops the strobe and lets the next key be accepted. Both guard times are plain inputs that are sampled every clock, so either one may be longer than the other and either may be changed while the block runs. A separate drive-enable output tells the pad ring when to put the held code on the shared bus. A hold flag shows whether a digit is currently registered.

Top module: `tone_steer_ctrl`

## Requirements
- R1: After reset `digit_code` is 0, `dly_strobe` is 0 and `guard_hold` is 0.
- R2: When `tone_present` has been sampled high on N consecutive rising edges, N being `present_guard`, the code sampled on the Nth edge is stored in `digit_code` at that edge and `guard_hold` rises at that same edge.
- R3: A run of high `tone_present` samples shorter than `present_guard` registers nothing: `digit_code` keeps its value and `guard_hold` stays 0.
- R4: `dly_strobe` rises exactly `SETTLE_CYC` rising edges after the edge that stored the code, and `digit_code` does not change in between.
- R5: While a digit is held, a run of low `tone_present` samples shorter than `absent_guard` neither ends the digit nor registers the code presented when the flag returns; `digit_code`, `dly_strobe` and `guard_hold` keep their values.
- R6: After `dly_strobe` is high, `absent_guard` consecutive low samples of `tone_present` clear `dly_strobe` and `guard_hold` at the last of those edges, after which a new tone can be registered.
- R7: `digit_drive` is high exactly while `out_en` is high; `digit_code` keeps the last registered code whatever `out_en` does.
- R8: `guard_hold` is high from the registering edge until the releasing edge, and `dly_strobe` is never high while `guard_hold` is low.
- R9: Low `tone_present` samples taken before `dly_strobe` has risen do not count towards `absent_guard`.
- R10: A guard value of 0 behaves exactly as a value of 1.
- R11: Guard values are read on every edge; a new `present_guard` applied during a running qualification is compared against the run length already reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tone_present | input | 1 | Signal-present flag from the tone decoder |
| tone_code | input | CODE_W | Key code from the tone decoder |
| out_en | input | 1 | Output drive request; the pad ring pulls it high when undriven |
| present_guard | input | TIMER_W | Tone-present guard time in clock cycles |
| absent_guard | input | TIMER_W | Tone-absent guard time in clock cycles |
| digit_code | output | CODE_W | Last registered key code |
| digit_drive | output | 1 | High when the pads should drive `digit_code`, else high impedance |
| dly_strobe | output | 1 | Delayed steering strobe, high while a settled digit is held |
| guard_hold | output | 1 | High while a registered digit is held |

## Verification
The bench builds the block with `TIMER_W` of 8 and `SETTLE_CYC` of 3, so that full qualify, settle and release sequences take only a few dozen cycles and the settle window is short enough to overlap with an early tone drop. Guard values run from 0 up to 30, which covers the zero-as-one case, a present guard shorter than the absent guard and the reverse, and a present guard lowered in the middle of a qualification.

// File: rtl/tone_steer_pkg.sv
// Shared types for the tone steering controller.
// Assumes: nothing beyond a 2-bit state encoding.
package tone_steer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,   // waiting for a tone
        ST_QUAL_P  = 2'd1,   // counting tone-present cycles
        ST_HELD    = 2'd2,   // digit registered, tone on (or settling)
        ST_QUAL_A  = 2'd3    // digit registered, counting absence
    } steer_state_t;

endpackage

// File: rtl/tone_guard_counter.sv
// Run-length qualifier: counts consecutive cycles in which `run` is high
// and flags the cycle in which the count reaches `limit`.
// Assumes: a limit of 0 is treated as 1; the count restarts whenever
// `run` drops or the limit is reached, so it never exceeds limit-1.
module tone_guard_counter #(
    parameter int TIMER_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [TIMER_W-1:0] limit,
    output logic               hit
);

    logic [TIMER_W-1:0] cnt;
    logic [TIMER_W:0]   cnt_next;
    logic [TIMER_W-1:0] eff_limit;

    // Purpose: derive the effective limit and the hit condition.
    always_comb begin
        eff_limit = (limit == '0) ? TIMER_W'(1) : limit;
        cnt_next  = {1'b0, cnt} + (TIMER_W+1)'(1);
        hit       = run && (cnt_next >= {1'b0, eff_limit});
    end

    // Purpose: advance or restart the run counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || hit) begin
            cnt <= '0;
        end else begin
            cnt <= cnt_next[TIMER_W-1:0];
        end
    end

endmodule

// File: rtl/tone_settle_timer.sv
// Delays the steering strobe by SETTLE_CYC edges after a code capture.
// Assumes: `start` and `clear` are never high together; SETTLE_CYC >= 1.
module tone_settle_timer #(
    parameter int SETTLE_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic clear,
    input  logic held,
    output logic strobe
);

    localparam int CW = $clog2(SETTLE_CYC + 1);

    logic [CW-1:0] cnt;

    // Purpose: count settle cycles and raise the strobe at the end.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt    <= '0;
            strobe <= 1'b0;
        end else if (start) begin
            cnt    <= '0;
            strobe <= 1'b0;
        end else if (held && !strobe) begin
            if (cnt == CW'(SETTLE_CYC - 1)) begin
                strobe <= 1'b1;
            end else begin
                cnt <= cnt + CW'(1);
            end
        end
    end

endmodule

// File: rtl/tone_steer_ctrl.sv
// Tone steering guard-time controller (top).
// Qualifies the decoder's signal-present flag against a tone-present guard,
// captures the key code, raises a delayed strobe after a fixed settle
// period, tolerates short dropouts and releases after a tone-absent guard.
// Assumes: inputs are synchronous to clk; guard values may change any cycle.
module tone_steer_ctrl
    import tone_steer_pkg::*;
#(
    parameter int TIMER_W    = 16,
    parameter int SETTLE_CYC = 8,
    parameter int CODE_W     = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tone_present,
    input  logic [CODE_W-1:0]  tone_code,
    input  logic               out_en,
    input  logic [TIMER_W-1:0] present_guard,
    input  logic [TIMER_W-1:0] absent_guard,
    output logic [CODE_W-1:0]  digit_code,
    output logic               digit_drive,
    output logic               dly_strobe,
    output logic               guard_hold
);

    steer_state_t state, state_nx;
    logic         p_run, p_hit;
    logic         a_run, a_hit;

    // Purpose: decide which qualifier is counting this cycle.
    always_comb begin
        p_run = ((state == ST_IDLE) || (state == ST_QUAL_P)) && tone_present;
        a_run = (((state == ST_HELD) && dly_strobe) || (state == ST_QUAL_A))
                && !tone_present;
    end

    tone_guard_counter #(.TIMER_W(TIMER_W)) u_present_q (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (p_run),
        .limit (present_guard),
        .hit   (p_hit)
    );

    tone_guard_counter #(.TIMER_W(TIMER_W)) u_absent_q (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (a_run),
        .limit (absent_guard),
        .hit   (a_hit)
    );

    // Purpose: next-state logic of the steering sequence.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (p_hit)             state_nx = ST_HELD;
                else if (tone_present) state_nx = ST_QUAL_P;
            end
            ST_QUAL_P: begin
                if (p_hit)              state_nx = ST_HELD;
                else if (!tone_present) state_nx = ST_IDLE;
            end
            ST_HELD: begin
                if (a_hit)      state_nx = ST_IDLE;
                else if (a_run) state_nx = ST_QUAL_A;
            end
            ST_QUAL_A: begin
                if (tone_present) state_nx = ST_HELD;
                else if (a_hit)   state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Purpose: state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Purpose: output code register, loaded only on registration.
    always_ff @(posedge clk) begin
        if (!rst_n)     digit_code <= '0;
        else if (p_hit) digit_code <= tone_code;
    end

    tone_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (p_hit),
        .clear  (a_hit),
        .held   (guard_hold),
        .strobe (dly_strobe)
    );

    // Purpose: status and pad-drive outputs.
    always_comb begin
        guard_hold  = (state == ST_HELD) || (state == ST_QUAL_A);
        digit_drive = out_en;
    end

endmodule

// File: rtl/tone_steer_chk.sv
// Property checker for tone_steer_ctrl, attached by bind.
// Assumes: SETTLE_CYC matches the bound instance.
module tone_steer_chk #(
    parameter int CODE_W     = 4,
    parameter int SETTLE_CYC = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tone_present,
    input logic [CODE_W-1:0] digit_code,
    input logic              dly_strobe,
    input logic              guard_hold
);

    localparam int AW = $clog2(SETTLE_CYC + 2);

    logic [AW-1:0] hold_age;

    // Purpose: count edges since guard_hold rose, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || !guard_hold)           hold_age <= '0;
        else if (hold_age != AW'(SETTLE_CYC + 1)) hold_age <= hold_age + AW'(1);
    end

    p_strobe_in_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dly_strobe |-> guard_hold);

    p_code_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (guard_hold && $past(guard_hold)) |-> (digit_code == $past(digit_code)));

    p_settle_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dly_strobe) |-> (hold_age == AW'(SETTLE_CYC)));

    p_reg_needs_tone_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(guard_hold) |-> $past(tone_present));

    p_release_on_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(guard_hold) |-> (!$past(tone_present) && !dly_strobe));

endmodule

bind tone_steer_ctrl tone_steer_chk #(
    .CODE_W     (CODE_W),
    .SETTLE_CYC (SETTLE_CYC)
) u_steer_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tone_present (tone_present),
    .digit_code   (digit_code),
    .dly_strobe   (dly_strobe),
    .guard_hold   (guard_hold)
);

// File: tb/tone_steer_ctrl_tb_top.sv
// Bench for tone_steer_ctrl: behavioural reference compared every clock,
// plus scenario checks at chosen points.
module tone_steer_ctrl_tb_top;

    localparam int TW     = 8;
    localparam int SETTLE = 3;
    localparam int CW     = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tone_present = 1'b0;
    logic [CW-1:0] tone_code = '0;
    logic          out_en = 1'b1;
    logic [TW-1:0] present_guard = 8'd5;
    logic [TW-1:0] absent_guard = 8'd4;
    logic [CW-1:0] digit_code;
    logic          digit_drive;
    logic          dly_strobe;
    logic          guard_hold;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    tone_steer_ctrl #(.TIMER_W(TW), .SETTLE_CYC(SETTLE), .CODE_W(CW)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .tone_present  (tone_present),
        .tone_code     (tone_code),
        .out_en        (out_en),
        .present_guard (present_guard),
        .absent_guard  (absent_guard),
        .digit_code    (digit_code),
        .digit_drive   (digit_drive),
        .dly_strobe    (dly_strobe),
        .guard_hold    (guard_hold)
    );

    // Reference model state
    int m_held = 0, m_hi = 0, m_lo = 0, m_settle = 0, m_strobe = 0, m_code = 0;

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // Reference model updated on every edge from the sampled inputs.
    always @(posedge clk) begin
        int pg, ag, old_strobe;
        cycles++;
        pg = (present_guard == 0) ? 1 : int'(present_guard);
        ag = (absent_guard == 0) ? 1 : int'(absent_guard);
        if (!rst_n) begin
            m_held = 0; m_hi = 0; m_lo = 0; m_settle = 0; m_strobe = 0; m_code = 0;
        end else if (m_held == 0) begin
            if (tone_present) begin
                m_hi++;
                if (m_hi >= pg) begin
                    m_code = int'(tone_code); m_held = 1; m_hi = 0;
                    m_settle = 0; m_strobe = 0;
                end
            end else m_hi = 0;
        end else begin
            old_strobe = m_strobe;
            if (old_strobe == 1 && !tone_present) begin
                m_lo++;
                if (m_lo >= ag) begin
                    m_held = 0; m_strobe = 0; m_lo = 0;
                end
            end else m_lo = 0;
            if (old_strobe == 0) begin
                m_settle++;
                if (m_settle == SETTLE) m_strobe = 1;
            end
        end
    end

    // Per-cycle comparison just after each edge.
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            check("R2 code", int'(digit_code), m_code);
            check("R4 strobe", int'(dly_strobe), m_strobe);
            check("R8 hold", int'(guard_hold), m_held);
            check("R7 drive", int'(digit_drive), int'(out_en));
        end
    end

    task automatic drive(bit tp, int code, int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tone_present = tp;
            tone_code    = CW'(code);
        end
    endtask

    task automatic settle_sample();
        @(posedge clk);
        #1;
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle_sample();
        check("R1 code", int'(digit_code), 0);
        check("R1 strobe", int'(dly_strobe), 0);
        check("R1 hold", int'(guard_hold), 0);

        // Burst of 4 against a guard of 5
        drive(1, 5, 4); drive(0, 5, 3);
        settle_sample();
        check("R3 hold", int'(guard_hold), 0);
        check("R3 code", int'(digit_code), 0);

        // Valid tone
        drive(1, 9, 12);
        settle_sample();
        check("R2 code", int'(digit_code), 9);
        check("R2 strobe", int'(dly_strobe), 1);

        // Dropout of 3 against absent guard 4, new code on return
        drive(0, 2, 3); drive(1, 2, 3);
        settle_sample();
        check("R5 code", int'(digit_code), 9);
        check("R5 strobe", int'(dly_strobe), 1);
        check("R5 hold", int'(guard_hold), 1);

        // Release
        drive(0, 2, 4);
        settle_sample();
        check("R6 strobe", int'(dly_strobe), 0);
        check("R6 hold", int'(guard_hold), 0);

        // Tone drops during settle
        present_guard = 8'd2;
        drive(1, 3, 2); drive(0, 3, 3);
        settle_sample();
        check("R9 hold", int'(guard_hold), 1);
        check("R9 strobe", int'(dly_strobe), 1);
        check("R9 code", int'(digit_code), 3);
        drive(0, 3, 4);
        settle_sample();
        check("R6 hold after settle drop", int'(guard_hold), 0);

        // Zero guards
        present_guard = 8'd0; absent_guard = 8'd0;
        drive(1, 12, 1); drive(0, 0, 3);
        settle_sample();
        check("R10 code", int'(digit_code), 12);
        check("R10 strobe", int'(dly_strobe), 1);
        drive(0, 0, 1);
        settle_sample();
        check("R10 hold", int'(guard_hold), 0);

        // Output enable
        @(negedge clk); out_en = 1'b0;
        settle_sample();
        check("R7 drive off", int'(digit_drive), 0);
        check("R7 code kept", int'(digit_code), 12);
        @(negedge clk); out_en = 1'b1;
        settle_sample();
        check("R7 drive on", int'(digit_drive), 1);

        // Runtime guard change, absent guard longer than present
        present_guard = 8'd20; absent_guard = 8'd30;
        drive(1, 7, 10);
        settle_sample();
        check("R11 hold before", int'(guard_hold), 0);
        @(negedge clk); present_guard = 8'd6;
        settle_sample();
        check("R11 hold", int'(guard_hold), 1);
        check("R11 code", int'(digit_code), 7);
        drive(1, 7, 5); drive(0, 7, 29);
        settle_sample();
        check("R5 long absent", int'(guard_hold), 1);
        drive(0, 7, 1);
        settle_sample();
        check("R6 long absent", int'(guard_hold), 0);

        // Second digit after release
        present_guard = 8'd4; absent_guard = 8'd2;
        drive(1, 15, 8); drive(0, 0, 4);
        settle_sample();
        check("R2 second digit", int'(digit_code), 15);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule